// File: doc/BRIEF.md
# NAND Flash Register Front End

This block sits between a simple memory-mapped register bus and a byte-wide NAND flash strobe engine. Software programs commands, addresses and data bytes by writing three separate registers. Each such write becomes one bus-cycle request of its own type, handed to the strobe engine over a valid/ready pair that carries a 2-bit kind and a data byte. A read of the data register issues a read cycle. The bus handshake completes only when the engine returns the flash byte.

The block also holds the control, configuration, status, timing and transfer-count registers. It owns the interrupt logic. The flash ready/busy line is synchronised, shown in status and turned into an edge interrupt. The transfer counter counts down once per data byte and raises an interrupt when it reaches zero. Only one bus cycle can be outstanding, so a second launching write stalls the register bus until the first has been accepted.

Top module: `nand_regfront`

## Requirements
- R1: After reset, configuration, interrupt enable, interrupt status, control, timing and transfer count all read zero, no cycle request is pending, `flash_ce_n` is 1 and `irq` is 0.
- R2: A write to offset 0x08 launches a cycle of kind 0 (command), 0x04 launches kind 1 (address) and 0x00 launches kind 2 (data write). Each carries write-data bits [7:0] as `cyc_byte`, and `cyc_valid`, kind and byte stay stable until `cyc_ready` is seen.
- R3: A write to any of those three offsets holds `bus_ready` low while an earlier cycle request is still pending.
- R4: A read of offset 0x00 launches a cycle of kind 3. The read completes with the byte returned on `rd_byte` in bits [7:0] and zero above.
- R5: `flash_ce_n` is 0 while configuration bit 5 is set. Otherwise it is 0 exactly while a cycle request is pending.
- R6: Writing 1 to control bit 2 (offset 0x10) clears the configuration register (0x14) and the interrupt enable register (0x20). Control bit 2 always reads back 0.
- R7: Writing 1 to control bit 1 gives a single-cycle `ecc_clear` pulse. Control bit 0 is stored, read back and driven on `dma_run`, and any write to the stop register (0x0C) clears it.
- R8: The transfer count register (0x30) loads on write. It decrements by one for each accepted cycle of kind 2 or 3 while nonzero, and a load in the same cycle wins over the decrement.
- R9: A decrement from 1 to 0 sets interrupt bit 1.
- R10: `flash_rb` passes through a two-stage synchroniser. Status bit 0 (0x18) shows the synchronised level and status bit 1 shows a pending cycle request. A rising edge of the synchronised level sets interrupt bit 0 once, and a steady high level does not set it again.
- R11: Writing 1s to 0x28 clears interrupt status bits, and writing 1s to 0x24 sets them. A hardware event in the same cycle as a clear leaves its bit set. Interrupt status reads at 0x1C.
- R12: `irq` is the OR of the interrupt status ANDed with the enable register (0x20). Offset 0x24 reads that masked status.
- R13: The timing register (0x2C) reads back what was written and drives `tim_cfg`. The configuration register drives `cfg_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| cyc_valid | output | 1 | Bus-cycle request pending |
| cyc_ready | input | 1 | Strobe engine accepts the request |
| cyc_kind | output | 2 | 0 command, 1 address, 2 data write, 3 data read |
| cyc_byte | output | 8 | Byte to drive |
| rd_byte_valid | input | 1 | Engine returns a read byte |
| rd_byte | input | 8 | Byte read from flash |
| flash_rb | input | 1 | Flash ready/busy line, 1 = ready, asynchronous |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| ecc_clear | output | 1 | One-cycle ECC accumulator clear |
| dma_run | output | 1 | Block transfer start flag |
| cfg_mode | output | 6 | Configuration register contents |
| tim_cfg | output | 32 | Timing register contents |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land in one cycle. In the first, the strobe engine accepts the data cycle that takes the transfer count from 1 to 0 while a register write to the interrupt clear register hits the same bit. In the second, a load of the transfer count coincides with a decrement. The bench provokes both by holding `cyc_ready` low with a data cycle pending and then raising it on the same edge that accepts the competing register write. It then reads back the interrupt status or the count: the bit must stay set and the loaded value must survive unchanged. Sweeps over every byte value for the three write kinds and over counts 1 to 8 surround these collisions.

// File: rtl/nand_regfront.sv
module nand_regfront #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int TIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              cyc_valid,
  input  logic              cyc_ready,
  output logic [1:0]        cyc_kind,
  output logic [7:0]        cyc_byte,
  input  logic              rd_byte_valid,
  input  logic [7:0]        rd_byte,
  input  logic              flash_rb,
  output logic              flash_ce_n,
  output logic              ecc_clear,
  output logic              dma_run,
  output logic [5:0]        cfg_mode,
  output logic [TIM_W-1:0]  tim_cfg,
  output logic              irq
);
  localparam logic [3:0] W_DATA = 4'd0,  W_ADDR = 4'd1,  W_CMD  = 4'd2,  W_STOP = 4'd3;
  localparam logic [3:0] W_CTRL = 4'd4,  W_CFG  = 4'd5,  W_STAT = 4'd6,  W_IRAW = 4'd7;
  localparam logic [3:0] W_IEN  = 4'd8,  W_ISET = 4'd9,  W_ICLR = 4'd10, W_TIM  = 4'd11;
  localparam logic [3:0] W_CNT  = 4'd12;
  localparam logic [1:0] K_CMD = 2'd0, K_ADR = 2'd1, K_WR = 2'd2, K_RD = 2'd3;

  logic [3:0] widx;
  assign widx = bus_addr[5:2];

  logic [5:0]       cfg_q;
  logic [1:0]       ien_q, raw_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TIM_W-1:0] tim_q;
  logic             run_q, eclr_q;
  logic             rd_wait, rd_have;
  logic [7:0]       rd_buf;
  logic             rb_m, rb_s, rb_d;

  logic is_launch, launch_rd, rd_start, acc, wr;
  assign is_launch = (widx == W_DATA) || (widx == W_ADDR) || (widx == W_CMD);
  assign launch_rd = bus_valid && !bus_write && (widx == W_DATA);
  assign rd_start  = launch_rd && !rd_wait && !cyc_valid;

  always_comb begin
    if (bus_valid && bus_write && is_launch) bus_ready = !cyc_valid && !rd_wait;
    else if (launch_rd)                      bus_ready = rd_have;
    else                                     bus_ready = 1'b1;
  end

  assign acc = bus_valid && bus_ready;
  assign wr  = acc && bus_write;

  logic [1:0] wr_kind;
  always_comb begin
    case (widx)
      W_CMD:   wr_kind = K_CMD;
      W_ADDR:  wr_kind = K_ADR;
      default: wr_kind = K_WR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid <= 1'b0;
      cyc_kind  <= K_CMD;
      cyc_byte  <= 8'h00;
    end else if (wr && is_launch) begin
      cyc_valid <= 1'b1;
      cyc_kind  <= wr_kind;
      cyc_byte  <= bus_wdata[7:0];
    end else if (rd_start) begin
      cyc_valid <= 1'b1;
      cyc_kind  <= K_RD;
      cyc_byte  <= 8'h00;
    end else if (cyc_valid && cyc_ready) begin
      cyc_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_wait <= 1'b0;
      rd_have <= 1'b0;
      rd_buf  <= 8'h00;
    end else begin
      if (rd_start) rd_wait <= 1'b1;
      if (rd_wait && !rd_have && rd_byte_valid) begin
        rd_have <= 1'b1;
        rd_buf  <= rd_byte;
      end
      if (rd_have && launch_rd) begin
        rd_have <= 1'b0;
        rd_wait <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ien_q  <= '0;
      run_q  <= 1'b0;
      eclr_q <= 1'b0;
      tim_q  <= '0;
    end else begin
      eclr_q <= wr && (widx == W_CTRL) && bus_wdata[1];
      if (wr && widx == W_CTRL) begin
        run_q <= bus_wdata[0];
        if (bus_wdata[2]) begin
          cfg_q <= '0;
          ien_q <= '0;
        end
      end
      if (wr && widx == W_STOP) run_q <= 1'b0;
      if (wr && widx == W_CFG)  cfg_q <= bus_wdata[5:0];
      if (wr && widx == W_IEN)  ien_q <= bus_wdata[1:0];
      if (wr && widx == W_TIM)  tim_q <= bus_wdata[TIM_W-1:0];
    end
  end

  logic cnt_load, cnt_dec, cnt_evt, rdy_evt;
  assign cnt_load = wr && (widx == W_CNT);
  assign cnt_dec  = cyc_valid && cyc_ready && cyc_kind[1] && (cnt_q != '0);
  assign cnt_evt  = cnt_dec && !cnt_load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_load) cnt_q <= bus_wdata[CNT_W-1:0];
    else if (cnt_dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rb_m, rb_s, rb_d} <= 3'b000;
    else        {rb_m, rb_s, rb_d} <= {flash_rb, rb_m, rb_s};
  end
  assign rdy_evt = rb_s && !rb_d;

  logic [1:0] clr_m, set_m;
  assign clr_m = (wr && widx == W_ICLR) ? bus_wdata[1:0] : 2'b00;
  assign set_m = (wr && widx == W_ISET) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_m) | set_m | {cnt_evt, rdy_evt};
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      W_DATA: bus_rdata[7:0]       = rd_buf;
      W_CTRL: bus_rdata[0]         = run_q;
      W_CFG:  bus_rdata[5:0]       = cfg_q;
      W_STAT: bus_rdata[1:0]       = {cyc_valid, rb_s};
      W_IRAW: bus_rdata[1:0]       = raw_q;
      W_IEN:  bus_rdata[1:0]       = ien_q;
      W_ISET: bus_rdata[1:0]       = raw_q & ien_q;
      W_TIM:  bus_rdata[TIM_W-1:0] = tim_q;
      W_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  assign flash_ce_n = !(cfg_q[5] || cyc_valid);
  assign ecc_clear  = eclr_q;
  assign dma_run    = run_q;
  assign cfg_mode   = cfg_q;
  assign tim_cfg    = tim_q;
  assign irq        = |(raw_q & ien_q);

  assert_launch_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && is_launch && cyc_valid) |-> !bus_ready);

  assert_cycle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_kind) && $stable(cyc_byte)));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_ready && cyc_kind[1] && cnt_q != '0 && !cnt_load)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == W_CTRL && bus_wdata[2]) |=> (cfg_mode == '0 && ien_q == '0));

  assert_ready_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_s) |=> raw_q[0]);

  assert_count_zero_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && cyc_valid && cyc_ready && cyc_kind[1] && !cnt_load) |=> raw_q[1]);
endmodule

// File: tb/nand_regfront_bench.sv
module nand_regfront_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        bus_valid = 0, bus_write = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        cyc_valid, cyc_ready = 1;
  logic [1:0]  cyc_kind;
  logic [7:0]  cyc_byte;
  logic        rd_byte_valid = 0;
  logic [7:0]  rd_byte = 0;
  logic        flash_rb = 0;
  logic        flash_ce_n, ecc_clear, dma_run, irq;
  logic [5:0]  cfg_mode;
  logic [31:0] tim_cfg;

  nand_regfront u_nand_regfront (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .cyc_valid(cyc_valid), .cyc_ready(cyc_ready),
    .cyc_kind(cyc_kind), .cyc_byte(cyc_byte), .rd_byte_valid(rd_byte_valid),
    .rd_byte(rd_byte), .flash_rb(flash_rb), .flash_ce_n(flash_ce_n),
    .ecc_clear(ecc_clear), .dma_run(dma_run), .cfg_mode(cfg_mode),
    .tim_cfg(tim_cfg), .irq(irq));

  int n_chk = 0, n_fail = 0, n_acc = 0;
  logic [1:0] last_kind;
  logic [7:0] last_byte, rd_pat = 8'h00;

  always @(posedge clk) begin
    rd_byte_valid <= cyc_valid && cyc_ready && cyc_kind == 2'd3;
    rd_byte       <= rd_pat;
    if (cyc_valid && cyc_ready) begin
      n_acc     <= n_acc + 1;
      last_kind <= cyc_kind;
      last_byte <= cyc_byte;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_valid = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    d = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 0;
  endtask

  task automatic expect_reg(input logic [5:0] a, input logic [31:0] e, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == e, req, v, e);
  endtask

  function automatic string tag(input int k);
    return (k == 3) ? "R4" : "R2";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(flash_ce_n == 1 && irq == 0 && cyc_valid == 0, "R1 outputs", {flash_ce_n, irq, cyc_valid}, 3'b100);
    expect_reg(6'h14, 0, "R1 cfg");
    expect_reg(6'h20, 0, "R1 ien");
    expect_reg(6'h1C, 0, "R1 int");
    expect_reg(6'h10, 0, "R1 ctrl");
    expect_reg(6'h30, 0, "R1 count");
    expect_reg(6'h2C, 0, "R1 timing");

    // R2 sweep every byte over the three write kinds
    for (int k = 0; k < 3; k++) begin
      for (int b = 0; b < 256; b++) begin
        logic [5:0] a;
        a = (k == 0) ? 6'h08 : (k == 1) ? 6'h04 : 6'h00;
        base = n_acc;
        wr(a, {24'hABCDEF, b[7:0]});
        check(n_acc == base + 1 && last_kind == k[1:0] && last_byte == b[7:0],
              "R2 launch", {last_kind, last_byte}, {k[1:0], b[7:0]});
      end
    end

    // R4 data reads
    for (int b = 0; b < 256; b += 17) begin
      rd_pat = b[7:0];
      base = n_acc;
      rd(6'h00, v);
      check(v == {24'h0, b[7:0]} && last_kind == 2'd3 && n_acc == base + 1, tag(3), v, b);
    end

    // R3 stall and R5 chip enable while pending
    cyc_ready = 0;
    wr(6'h08, 32'hA5);
    check(cyc_valid == 1 && flash_ce_n == 0, "R5 ce during pending", flash_ce_n, 0);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 6'h04; bus_wdata = 32'h3C;
    for (int i = 0; i < 3; i++) begin
      #1; check(bus_ready == 0, "R3 stall", bus_ready, 0);
      @(negedge clk);
    end
    base = n_acc;
    cyc_ready = 1;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; bus_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(n_acc == base + 2 && last_kind == 2'd1 && last_byte == 8'h3C, "R3 second launch", last_byte, 8'h3C);
    check(flash_ce_n == 1, "R5 ce idle", flash_ce_n, 1);
    wr(6'h14, 32'h20);
    @(negedge clk);
    check(flash_ce_n == 0 && cfg_mode == 6'h20, "R5 forced ce R13 cfg_mode", {flash_ce_n, cfg_mode}, 6'h20);

    // R6 soft reset
    wr(6'h14, 32'h3F);
    wr(6'h20, 32'h3);
    wr(6'h10, 32'h4);
    expect_reg(6'h14, 0, "R6 cfg cleared");
    expect_reg(6'h20, 0, "R6 ien cleared");
    expect_reg(6'h10, 0, "R6 ctrl bit2 reads 0");

    // R7 ecc clear pulse, run flag, stop
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 6'h10; bus_wdata = 32'h3;
    @(posedge clk); #1; bus_valid = 0;
    @(negedge clk);
    check(ecc_clear == 1, "R7 pulse high", ecc_clear, 1);
    @(negedge clk);
    check(ecc_clear == 0, "R7 pulse one cycle", ecc_clear, 0);
    check(dma_run == 1, "R7 run set", dma_run, 1);
    expect_reg(6'h10, 1, "R7 ctrl readback");
    wr(6'h0C, 32'h0);
    check(dma_run == 0, "R7 stop", dma_run, 0);

    // R8/R9 count sweep
    for (int n = 1; n <= 8; n++) begin
      wr(6'h28, 32'h3);
      wr(6'h30, n);
      for (int j = 1; j <= n; j++) begin
        if (j % 2 == 0) rd(6'h00, v); else wr(6'h00, j);
        expect_reg(6'h30, n - j, "R8 count step");
      end
      wr(6'h00, 8'h11);
      expect_reg(6'h30, 0, "R8 holds at zero");
      expect_reg(6'h1C, 2, "R9 zero interrupt");
    end
    wr(6'h30, 5);
    wr(6'h08, 1);
    wr(6'h04, 2);
    expect_reg(6'h30, 5, "R8 cmd/addr do not count");

    // R8 load wins over decrement
    cyc_ready = 0;
    wr(6'h30, 3);
    wr(6'h00, 8'h55);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 6'h30; bus_wdata = 32'h9;
    cyc_ready = 1;
    @(posedge clk); #1; bus_valid = 0;
    expect_reg(6'h30, 9, "R8 load beats decrement");

    // R11 event beats clear in same cycle
    wr(6'h28, 32'h3);
    cyc_ready = 0;
    wr(6'h30, 1);
    wr(6'h00, 8'h66);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 6'h28; bus_wdata = 32'h2;
    cyc_ready = 1;
    @(posedge clk); #1; bus_valid = 0;
    expect_reg(6'h1C, 2, "R11 event wins over clear");
    wr(6'h28, 32'h2);
    expect_reg(6'h1C, 0, "R11 clear");
    wr(6'h24, 32'h1);
    expect_reg(6'h1C, 1, "R11 set");
    wr(6'h28, 32'h1);

    // R10 ready sync and edge interrupt
    expect_reg(6'h18, 0, "R10 status low");
    flash_rb = 1;
    repeat (5) @(posedge clk);
    expect_reg(6'h18, 1, "R10 status high");
    expect_reg(6'h1C, 1, "R10 edge interrupt");
    wr(6'h28, 32'h1);
    repeat (5) @(posedge clk);
    expect_reg(6'h1C, 0, "R10 level does not retrigger");
    cyc_ready = 0;
    wr(6'h08, 32'h70);
    expect_reg(6'h18, 3, "R10 status pending bit");
    cyc_ready = 1;
    repeat (2) @(posedge clk);

    // R12 masking
    wr(6'h24, 32'h2);
    @(negedge clk);
    check(irq == 0, "R12 masked off", irq, 0);
    wr(6'h20, 32'h2);
    @(negedge clk);
    check(irq == 1, "R12 enabled", irq, 1);
    expect_reg(6'h24, 2, "R12 masked read");
    wr(6'h20, 32'h1);
    @(negedge clk);
    check(irq == 0, "R12 other enable", irq, 0);

    // R13 timing register
    wr(6'h2C, 32'hDEAD_BEEF);
    expect_reg(6'h2C, 32'hDEAD_BEEF, "R13 timing readback");
    check(tim_cfg == 32'hDEAD_BEEF, "R13 timing output", tim_cfg, 32'hDEAD_BEEF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule